// File: doc/BRIEF.md
# Interrupt Identifier Priority Encoder

This block reduces the interrupt sources of a message-based CAN controller to one 8-bit identifier. The sources are one status request and the pending flags of message objects 1 to 15. Software reads the identifier to learn which source to service first. A code of 0 means nothing is pending. The status request has code 1. The top object, number 15, has code 2. Any other object n has code n + 2.

The block also holds the controller's 8-bit control register. Three of its bits drive this block:

- The global interrupt enable gates the level interrupt line.
- The status-change enable and the error enable decide which hardware events may set the status request.

The status request is latched. It clears only when software reads the identifier while the identifier shows 1. The object pending flags come from per-object storage outside this block. They are used as levels and encoded in the same cycle.

Top module: `intid_prio_enc`

## Requirements
- R1: After reset, `ctrl_rdata` reads 0x01 (only the initialization bit set), `int_id` reads 0 and `irq` is low.
- R2: A write with `ctrl_we` high updates the control register at the next clock edge. The stored bits are init 0x01, global interrupt enable 0x02, status-change enable 0x04, error enable 0x08, extra-functions enable 0x20 and configuration-change enable 0x40. Bits 0x10 and 0x80 always read 0.
- R3: If `stat_evt` is high in a cycle while the status-change enable (0x04) is set, `int_id` reads 1 from the next cycle. If that enable is clear, the event has no effect.
- R4: If `err_evt` is high in a cycle while the error enable (0x08) is set, `int_id` reads 1 from the next cycle. If that enable is clear, the event has no effect.
- R5: `int_id` reads 0 when the status request is clear and no bit of `obj_pend` is set.
- R6: When the status request is clear and object 15 is pending (`obj_pend` bit 14), `int_id` reads 2, whatever the state of the other objects.
- R7: When neither the status request nor object 15 is pending, `int_id` reads n + 2 for the lowest-numbered pending object n in 1..14. Object n is `obj_pend` bit n-1.
- R8: A latched status request makes `int_id` read 1 whatever `obj_pend` holds.
- R9: If `id_rd` is high in a cycle where `int_id` reads 1, the status request is cleared at the next edge. If `id_rd` is high while `int_id` reads any other value, the status request is unchanged.
- R10: If an enabled status or error event arrives in the same cycle as a clearing read, the status request stays set.
- R11: `irq` is high exactly when the global interrupt enable (0x02) is set and `int_id` is non-zero.
- R12: `int_id` and `irq` follow changes on `obj_pend` in the same cycle, with no register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control register write data |
| ctrl_rdata | output | 8 | Control register read data |
| stat_evt | input | 1 | Status-change event pulse from the protocol engine |
| err_evt | input | 1 | Error event pulse (warning or bus-off change) |
| id_rd | input | 1 | Software read strobe of the identifier |
| obj_pend | input | 15 | Per-object pending levels; bit i is object i+1 |
| int_id | output | 8 | Highest-priority pending source code |
| irq | output | 1 | Level interrupt request |

## Verification
The bench keeps its own model of the control bits and the status latch. It compares the identifier, the interrupt line and the control readback on every cycle.

Several corner cases are targeted:

- Mixed object patterns check that object 15 outranks lower objects and that the lowest of objects 1 to 14 wins. A reversed scan would report the highest pending object instead.
- A read taken while the identifier shows an object code must leave the status latch intact. A design that clears on any read would lose a status interrupt.
- An event arriving together with a clearing read must keep the latch set. A clear-priority design would drop that event.
- Events sent while their enable is clear must not change the identifier.

// File: rtl/intid_pkg.sv
package intid_pkg;

    localparam int CTRL_W = 8;

    // Bit positions inside the control byte (software decodes them).
    localparam int CB_INIT    = 0;
    localparam int CB_GIE     = 1;
    localparam int CB_STAT_IE = 2;
    localparam int CB_ERR_IE  = 3;
    localparam int CB_ADDL    = 5;
    localparam int CB_CFG     = 6;

    localparam logic [CTRL_W-1:0] CTRL_RESET = 8'h01;

    typedef struct packed {
        logic cfg_chg;
        logic addl_fn;
        logic err_ie;
        logic stat_ie;
        logic glob_ie;
        logic init;
    } ctrl_t;

    function automatic ctrl_t ctrl_unpack(input logic [CTRL_W-1:0] b);
        ctrl_t c;
        c.init    = b[CB_INIT];
        c.glob_ie = b[CB_GIE];
        c.stat_ie = b[CB_STAT_IE];
        c.err_ie  = b[CB_ERR_IE];
        c.addl_fn = b[CB_ADDL];
        c.cfg_chg = b[CB_CFG];
        return c;
    endfunction

    function automatic logic [CTRL_W-1:0] ctrl_pack(input ctrl_t c);
        logic [CTRL_W-1:0] b;
        b             = '0;
        b[CB_INIT]    = c.init;
        b[CB_GIE]     = c.glob_ie;
        b[CB_STAT_IE] = c.stat_ie;
        b[CB_ERR_IE]  = c.err_ie;
        b[CB_ADDL]    = c.addl_fn;
        b[CB_CFG]     = c.cfg_chg;
        return b;
    endfunction

endpackage

// File: rtl/intid_ctrl_reg.sv
module intid_ctrl_reg
    import intid_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CTRL_W-1:0] wdata,
    output ctrl_t             ctrl,
    output logic [CTRL_W-1:0] rdata
);

    typedef struct packed {
        ctrl_t ctrl;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.ctrl = ctrl_unpack(wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctrl <= ctrl_unpack(CTRL_RESET);
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl  = st_q.ctrl;
    assign rdata = ctrl_pack(st_q.ctrl);

endmodule

// File: rtl/intid_stat_req.sv
module intid_stat_req (
    input  logic clk,
    input  logic rst_n,
    input  logic stat_evt,
    input  logic err_evt,
    input  logic stat_ie,
    input  logic err_ie,
    input  logic clr,
    output logic req
);

    typedef struct packed {
        logic req;
    } state_t;

    state_t st_d, st_q;
    logic   set_now;

    always_comb begin
        st_d    = st_q;
        set_now = (stat_evt && stat_ie) || (err_evt && err_ie);
        // Set takes priority over a clearing read so no event is lost.
        if (set_now) begin
            st_d.req = 1'b1;
        end else if (clr) begin
            st_d.req = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req = st_q.req;

endmodule

// File: rtl/intid_obj_enc.sv
module intid_obj_enc #(
    parameter int NUM_OBJ = 15,
    parameter int ID_W    = 8
) (
    input  logic [NUM_OBJ-1:0] pend,
    output logic               hit,
    output logic [ID_W-1:0]    code
);

    localparam int LOW_N = NUM_OBJ - 1;
    localparam logic [ID_W-1:0] TOP_CODE = ID_W'(2);

    // Ripple chain over objects 1..NUM_OBJ-1: the first (lowest) pending wins.
    logic               found [LOW_N+1];
    logic [ID_W-1:0]    ccode [LOW_N+1];

    assign found[0] = 1'b0;
    assign ccode[0] = '0;

    for (genvar k = 1; k <= LOW_N; k++) begin : g_chain
        assign found[k] = found[k-1] || pend[k-1];
        assign ccode[k] = found[k-1] ? ccode[k-1]
                        : (pend[k-1] ? ID_W'(k + 2) : '0);
    end

    always_comb begin
        if (pend[NUM_OBJ-1]) begin
            hit  = 1'b1;
            code = TOP_CODE;
        end else begin
            hit  = found[LOW_N];
            code = ccode[LOW_N];
        end
    end

endmodule

// File: rtl/intid_prio_enc.sv
module intid_prio_enc
    import intid_pkg::*;
#(
    parameter int NUM_OBJ = 15,
    parameter int ID_W    = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctrl_we,
    input  logic [7:0]         ctrl_wdata,
    output logic [7:0]         ctrl_rdata,
    input  logic               stat_evt,
    input  logic               err_evt,
    input  logic               id_rd,
    input  logic [NUM_OBJ-1:0] obj_pend,
    output logic [ID_W-1:0]    int_id,
    output logic               irq
);

    localparam logic [ID_W-1:0] STAT_CODE = ID_W'(1);

    ctrl_t           ctrl;
    logic            stat_req;
    logic            obj_hit;
    logic [ID_W-1:0] obj_code;
    logic            stat_clr;

    intid_ctrl_reg u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctrl_we),
        .wdata (ctrl_wdata),
        .ctrl  (ctrl),
        .rdata (ctrl_rdata)
    );

    // Status sits above every object, so int_id shows 1 exactly when stat_req is set.
    assign stat_clr = id_rd && stat_req;

    intid_stat_req u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .stat_evt (stat_evt),
        .err_evt  (err_evt),
        .stat_ie  (ctrl.stat_ie),
        .err_ie   (ctrl.err_ie),
        .clr      (stat_clr),
        .req      (stat_req)
    );

    intid_obj_enc #(
        .NUM_OBJ (NUM_OBJ),
        .ID_W    (ID_W)
    ) u_enc (
        .pend (obj_pend),
        .hit  (obj_hit),
        .code (obj_code)
    );

    always_comb begin
        if (stat_req) begin
            int_id = STAT_CODE;
        end else begin
            int_id = obj_code;
        end
        irq = ctrl.glob_ie && (stat_req || obj_hit);
    end

endmodule

// File: rtl/intid_prio_enc_chk.sv
module intid_prio_enc_chk #(
    parameter int NUM_OBJ = 15,
    parameter int ID_W    = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [7:0]         ctrl_rdata,
    input logic               stat_evt,
    input logic               err_evt,
    input logic               id_rd,
    input logic [NUM_OBJ-1:0] obj_pend,
    input logic [ID_W-1:0]    int_id,
    input logic               irq
);

    // R2
    rsv_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rdata[7] == 1'b0 && ctrl_rdata[4] == 1'b0);

    // R3
    stat_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_evt && ctrl_rdata[2]) |=> (int_id == ID_W'(1)));

    // R4
    err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_evt && ctrl_rdata[3]) |=> (int_id == ID_W'(1)));

    // R5
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (obj_pend == '0 && int_id != ID_W'(1)) |-> (int_id == '0));

    // R8
    stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_id == ID_W'(1) && !id_rd) |=> (int_id == ID_W'(1)));

    // R9
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (id_rd && int_id == ID_W'(1) && !stat_evt && !err_evt) |=> (int_id != ID_W'(1)));

    // R11
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ctrl_rdata[1] && int_id != '0));

endmodule

bind intid_prio_enc intid_prio_enc_chk #(
    .NUM_OBJ (NUM_OBJ),
    .ID_W    (ID_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_rdata (ctrl_rdata),
    .stat_evt   (stat_evt),
    .err_evt    (err_evt),
    .id_rd      (id_rd),
    .obj_pend   (obj_pend),
    .int_id     (int_id),
    .irq        (irq)
);

// File: tb/intid_prio_enc_tb.sv
module intid_prio_enc_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_we = 1'b0;
    logic [7:0]  ctrl_wdata = '0;
    logic [7:0]  ctrl_rdata;
    logic        stat_evt = 1'b0;
    logic        err_evt = 1'b0;
    logic        id_rd = 1'b0;
    logic [14:0] obj_pend = '0;
    logic [7:0]  int_id;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // behavioural model state
    logic [7:0] m_ctrl = 8'h01;
    bit         m_stat = 0;

    always #2 clk = ~clk;  // 250 MHz

    intid_prio_enc u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_we    (ctrl_we),
        .ctrl_wdata (ctrl_wdata),
        .ctrl_rdata (ctrl_rdata),
        .stat_evt   (stat_evt),
        .err_evt    (err_evt),
        .id_rd      (id_rd),
        .obj_pend   (obj_pend),
        .int_id     (int_id),
        .irq        (irq)
    );

    function automatic int exp_id(input bit st, input logic [14:0] p);
        if (st) return 1;
        if (p[14]) return 2;
        for (int n = 1; n <= 14; n++) begin
            if (p[n-1]) return n + 2;
        end
        return 0;
    endfunction

    task automatic check(input string tag, input int act, input int expv, input string what);
        n_chk++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    // One cycle: drive inputs after the falling edge, compare, then advance model at the rising edge.
    task automatic step(input bit we, input logic [7:0] wd, input bit sev, input bit eev,
                        input bit rd, input logic [14:0] pend, input string tag);
        int  e;
        bit  nstat;
        logic [7:0] nctrl;
        @(negedge clk);
        ctrl_we = we; ctrl_wdata = wd; stat_evt = sev; err_evt = eev;
        id_rd = rd; obj_pend = pend;
        #1;
        e = exp_id(m_stat, pend);
        check(tag, int'(int_id), e, "int_id");
        check(tag, int'(irq), int'(m_ctrl[1] && e != 0), "irq");
        check(tag, int'(ctrl_rdata), int'(m_ctrl), "ctrl_rdata");
        nctrl = we ? (wd & 8'h6F) : m_ctrl;
        nstat = m_stat;
        if ((sev && m_ctrl[2]) || (eev && m_ctrl[3])) nstat = 1;
        else if (rd && e == 1) nstat = 0;
        @(posedge clk);
        m_ctrl = nctrl;
        m_stat = nstat;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        step(0, 0, 0, 0, 0, '0, "R1");
        step(0, 0, 0, 0, 0, '0, "R5");
        // R2 control write and reserved bits
        step(1, 8'hFF, 0, 0, 0, '0, "R2");
        step(0, 0, 0, 0, 0, '0, "R2");
        step(1, 8'h00, 0, 0, 0, '0, "R2");
        step(0, 0, 0, 0, 0, '0, "R2");
        // R3 R4 events ignored while enables are clear
        step(0, 0, 1, 0, 0, '0, "R3");
        step(0, 0, 0, 1, 0, '0, "R4");
        step(0, 0, 0, 0, 0, '0, "R4");
        // R7 R12 object patterns, interrupts globally off (R11)
        step(0, 0, 0, 0, 0, 15'h0004, "R7");
        step(0, 0, 0, 0, 0, 15'h0102, "R7");
        step(0, 0, 0, 0, 0, 15'h2000, "R7");
        step(0, 0, 0, 0, 0, 15'h0001, "R12");
        step(0, 0, 0, 0, 0, 15'h4000, "R6");
        step(0, 0, 0, 0, 0, 15'h4001, "R6");
        step(0, 0, 0, 0, 0, 15'h7FFF, "R6");
        step(0, 0, 0, 0, 0, '0, "R5");
        // enable global, status and error interrupts
        step(1, 8'h0E, 0, 0, 0, '0, "R2");
        step(0, 0, 0, 0, 0, 15'h0010, "R11");
        step(0, 0, 1, 0, 0, 15'h0010, "R3");
        step(0, 0, 0, 0, 0, 15'h4010, "R8");
        step(0, 0, 0, 0, 1, 15'h4010, "R9");
        step(0, 0, 0, 0, 0, 15'h4010, "R9");
        step(0, 0, 0, 0, 1, 15'h4010, "R9");
        step(0, 0, 0, 0, 0, 15'h0000, "R9");
        step(0, 0, 0, 1, 0, '0, "R4");
        step(0, 0, 0, 0, 0, '0, "R8");
        step(0, 0, 1, 0, 1, '0, "R10");
        step(0, 0, 0, 0, 0, '0, "R10");
        step(0, 0, 0, 0, 1, '0, "R9");
        step(0, 0, 0, 0, 0, '0, "R11");
        // status enable only: error event ignored
        step(1, 8'h06, 0, 0, 0, '0, "R2");
        step(0, 0, 0, 1, 0, '0, "R4");
        step(0, 0, 0, 0, 0, '0, "R4");
        // irq off with status pending
        step(1, 8'h04, 1, 0, 0, '0, "R3");
        step(0, 0, 0, 0, 0, 15'h0200, "R11");
        step(0, 0, 0, 0, 1, 15'h0200, "R9");
        step(0, 0, 0, 0, 0, 15'h0200, "R7");
        for (int n = 1; n <= 15; n++) begin
            step(0, 0, 0, 0, 0, 15'(1 << (n - 1)), "R7");
        end
        step(0, 0, 0, 0, 0, '0, "R5");
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule